// File: doc/BRIEF.md
# Control Endpoint Transaction Responder

This block answers the host on one control endpoint of a full-speed device, one packet at a time. A packet decoder upstream gives it token strobes (SETUP, IN, OUT), strobes for received data packets with their byte count, and strobes for host ACK handshakes. For each transaction the block decides what the device sends back: an ACK, a NAK, a STALL or a data packet of a given length. It also tells the receive buffer when to keep incoming bytes and tells the transmit FIFO when an IN packet has been acknowledged.

Firmware arms IN replies with a transmit-enable pulse and can force the endpoint into a stall. The transmit-enable flag clears itself once the host has acknowledged the packet that emptied the FIFO. If firmware arms the flag while the FIFO is empty, the next IN token gets a zero-length packet. When the host ACK for an IN packet does not arrive within a bounded wait, the FIFO contents and the flag stay as they were, so the same data is sent again on the next IN.

Top module: `usb_ctrl_ep_responder`

## Requirements
- R1: A SETUP token (code 0) followed by an 8-byte data packet is answered with ACK (code 0), with `rx_wr` high and `rsp_len` = 8. This clears a pending stall.
- R2: A SETUP data packet of any length other than 8 gets no response and no write, and the block returns to accepting tokens.
- R3: After an OUT token (code 2), a data packet whose length is at most `rx_space` is answered with ACK plus `rx_wr` and `rsp_len` = length. A longer one gets NAK (code 1) and no write.
- R4: While stalled (after an `fw_stall` pulse), IN tokens and OUT data are answered with STALL (code 2) and nothing is written. STALL takes priority over NAK and over sending data, and `tx_en` is left unchanged.
- R5: An IN token (code 1) while `tx_en` is 0 is answered with NAK. No handshake wait follows, so the next token is handled at once.
- R6: An IN token while `tx_en` is 1 is answered with DATA (code 3) of length min(`tx_fill`, MAX_PKT). `in_done` pulses only after the host ACK that follows.
- R7: When the acknowledged packet carried every byte left in the FIFO (`tx_fill` equal to its length), `tx_en` drops to 0. Otherwise `tx_en` stays 1.
- R8: An `fw_arm` pulse while `tx_fill` is 0 makes the next IN get DATA with length 0. Its ACK clears `tx_en`.
- R9: If no host ACK arrives within TIMEOUT cycles after DATA, the block returns to idle without `in_done`, and `tx_en` stays 1. The next IN sends the same length again.
- R10: Every response appears on `rsp_valid` for exactly one cycle, on the clock edge that samples the token or data strobe causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token code: 0 SETUP, 1 IN, 2 OUT |
| dat_valid | input | 1 | Received data packet strobe |
| dat_len | input | LEN_W | Byte count of the received data packet |
| host_ack | input | 1 | Host ACK handshake strobe |
| fw_arm | input | 1 | Firmware pulse that sets the transmit-enable flag |
| fw_stall | input | 1 | Firmware pulse that forces the stall condition |
| rx_space | input | LEN_W | Free bytes in the receive buffer |
| tx_fill | input | LEN_W | Bytes waiting in the transmit FIFO |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | Response code: 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| rsp_len | output | LEN_W | Data length for DATA, or bytes written for ACK |
| rx_wr | output | 1 | Commit received bytes to the receive buffer |
| tx_en | output | 1 | Transmit-enable flag |
| in_done | output | 1 | IN packet acknowledged by the host; FIFO may release it |

## Verification
The bench targets the points where a plausible design slips. It sends an IN right after a NAK, which catches a design that waits for a handshake after NAK. It sends a SETUP of the wrong length, which a careless design would ACK or leave hanging. It sends an OUT that just overflows `rx_space`, which catches an off-by-one compare. It sends a FIFO that takes two packets to drain, which shows whether `tx_en` clears too early or never. It also covers the zero-length arm, and an IN whose ACK never comes, where a wrong design would drop the data or clear the flag. Finally it sets a stall while IN is armed, which a design with the wrong priority answers with data or NAK.

// File: rtl/usb_cep_pkg.sv
package usb_cep_pkg;
   typedef enum logic [1:0] {TK_SETUP = 2'd0, TK_IN = 2'd1, TK_OUT = 2'd2} tok_e;
   typedef enum logic [1:0] {RS_ACK = 2'd0, RS_NAK = 2'd1, RS_STALL = 2'd2, RS_DATA = 2'd3} rsp_e;
   typedef enum logic [1:0] {ST_IDLE, ST_SETUP_DAT, ST_OUT_DAT, ST_IN_HS} st_e;
endpackage

// File: rtl/cep_timer.sv
module cep_timer #(
   parameter int TIMEOUT = 16,
   parameter int TMR_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (TIMEOUT == 0) begin : g_none
         assign expired = 1'b0;
      end else begin : g_cnt
         logic [TMR_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (!run)     cnt <= '0;
            else if (!expired) cnt <= cnt + 1'b1;
         end
         assign expired = run && (cnt == TMR_W'(TIMEOUT - 1));

         // R9: the wait never outlasts its bound
         p_wait_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
            expired |=> !expired);
      end
   endgenerate
endmodule

// File: rtl/cep_txen_flag.sv
module cep_txen_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic drain,
   output logic tx_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_en <= 1'b0;
      else if (arm)   tx_en <= 1'b1;
      else if (drain) tx_en <= 1'b0;
   end

   // R7: flag only falls after the drained packet was acknowledged
   p_clear_on_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> $past(drain));
endmodule

// File: rtl/cep_reply_sel.sv
module cep_reply_sel
   import usb_cep_pkg::*;
#(
   parameter int LEN_W     = 7,
   parameter int MAX_PKT   = 8,
   parameter int SETUP_LEN = 8
) (
   input  logic             ev_in,
   input  logic             ev_setup_dat,
   input  logic             ev_out_dat,
   input  logic             stall,
   input  logic             tx_en,
   input  logic [LEN_W-1:0] dat_len,
   input  logic [LEN_W-1:0] rx_space,
   input  logic [LEN_W-1:0] tx_fill,
   output logic             r_valid,
   output rsp_e             r_kind,
   output logic [LEN_W-1:0] r_len,
   output logic             r_wr,
   output logic             in_sent
);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_PKT);
   localparam logic [LEN_W-1:0] SLEN = LEN_W'(SETUP_LEN);

   always_comb begin
      r_valid = 1'b0;
      r_kind  = RS_ACK;
      r_len   = '0;
      r_wr    = 1'b0;
      in_sent = 1'b0;
      if (ev_setup_dat) begin
         if (dat_len == SLEN) begin
            r_valid = 1'b1;
            r_wr    = 1'b1;
            r_len   = dat_len;
         end
      end else if (ev_out_dat) begin
         r_valid = 1'b1;
         if (stall)                 r_kind = RS_STALL;
         else if (dat_len > rx_space) r_kind = RS_NAK;
         else begin
            r_wr  = 1'b1;
            r_len = dat_len;
         end
      end else if (ev_in) begin
         r_valid = 1'b1;
         if (stall)       r_kind = RS_STALL;
         else if (!tx_en) r_kind = RS_NAK;
         else begin
            r_kind  = RS_DATA;
            r_len   = (tx_fill > CAP) ? CAP : tx_fill;
            in_sent = 1'b1;
         end
      end
   end
endmodule

// File: rtl/usb_ctrl_ep_responder.sv
module usb_ctrl_ep_responder
   import usb_cep_pkg::*;
#(
   parameter int LEN_W   = 7,
   parameter int MAX_PKT = 8,
   parameter int TIMEOUT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_valid,
   input  logic [1:0]       tok_kind,
   input  logic             dat_valid,
   input  logic [LEN_W-1:0] dat_len,
   input  logic             host_ack,
   input  logic             fw_arm,
   input  logic             fw_stall,
   input  logic [LEN_W-1:0] rx_space,
   input  logic [LEN_W-1:0] tx_fill,
   output logic             rsp_valid,
   output logic [1:0]       rsp_kind,
   output logic [LEN_W-1:0] rsp_len,
   output logic             rx_wr,
   output logic             tx_en,
   output logic             in_done
);
   localparam int SETUP_LEN = 8;
   localparam int TMR_W     = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

   generate
      if (MAX_PKT < 1 || MAX_PKT >= (1 << LEN_W)) begin : g_bad_pkt
         $error("MAX_PKT must be between 1 and 2**LEN_W-1");
      end
      if (SETUP_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("LEN_W too narrow for a setup packet");
      end
   endgenerate

   st_e              state;
   logic             stall_q;
   logic [LEN_W-1:0] pend_len;
   logic             expired;
   logic             ev_in, ev_setup_dat, ev_out_dat, ack_in, drain;
   logic             r_valid, r_wr, in_sent;
   rsp_e             r_kind;
   logic [LEN_W-1:0] r_len;

   assign ev_in        = (state == ST_IDLE) && tok_valid && (tok_kind == TK_IN);
   assign ev_setup_dat = (state == ST_SETUP_DAT) && dat_valid;
   assign ev_out_dat   = (state == ST_OUT_DAT) && dat_valid;
   assign ack_in       = (state == ST_IN_HS) && host_ack;
   assign drain        = ack_in && (pend_len == tx_fill);

   cep_timer #(.TIMEOUT(TIMEOUT), .TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .expired(expired));

   cep_reply_sel #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .SETUP_LEN(SETUP_LEN)) u_sel (
      .ev_in(ev_in), .ev_setup_dat(ev_setup_dat), .ev_out_dat(ev_out_dat),
      .stall(stall_q), .tx_en(tx_en), .dat_len(dat_len), .rx_space(rx_space),
      .tx_fill(tx_fill), .r_valid(r_valid), .r_kind(r_kind), .r_len(r_len),
      .r_wr(r_wr), .in_sent(in_sent));

   cep_txen_flag u_flag (
      .clk(clk), .rst_n(rst_n), .arm(fw_arm), .drain(drain), .tx_en(tx_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: if (tok_valid) begin
               if (tok_kind == TK_SETUP)    state <= ST_SETUP_DAT;
               else if (tok_kind == TK_OUT) state <= ST_OUT_DAT;
               else if (in_sent)            state <= ST_IN_HS;
            end
            ST_SETUP_DAT, ST_OUT_DAT: if (dat_valid || expired) state <= ST_IDLE;
            ST_IN_HS:                 if (host_ack || expired)  state <= ST_IDLE;
            default:                  state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q   <= 1'b0;
         pend_len  <= '0;
         rsp_valid <= 1'b0;
         rsp_kind  <= RS_ACK;
         rsp_len   <= '0;
         rx_wr     <= 1'b0;
         in_done   <= 1'b0;
      end else begin
         if (fw_stall)                  stall_q <= 1'b1;
         else if (ev_setup_dat && r_wr) stall_q <= 1'b0;
         if (in_sent) pend_len <= r_len;
         rsp_valid <= r_valid;
         rsp_kind  <= r_kind;
         rsp_len   <= r_len;
         rx_wr     <= r_wr;
         in_done   <= ack_in;
      end
   end

   // R3: a write is always paired with an ACK
   p_wr_is_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr |-> (rsp_valid && rsp_kind == RS_ACK));
   // R4: stall state forbids NAK and data replies
   p_stall_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_kind == RS_DATA || rsp_kind == RS_NAK)) |-> !$past(stall_q));
   // R5: data only goes out while enabled
   p_data_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RS_DATA) |-> $past(tx_en));
   // R6: data length capped, completion only out of the handshake wait
   p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RS_DATA) |-> (rsp_len <= LEN_W'(MAX_PKT)));
   p_done_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_done |-> ($past(state) == ST_IN_HS));
   // R9: timeout leaves the flag armed
   p_timeout_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IN_HS && expired && !host_ack) |=> tx_en);
endmodule

// File: tb/usb_ctrl_ep_responder_bench.sv
module usb_ctrl_ep_responder_bench;
   localparam int LEN_W = 7;
   localparam int MAX_PKT = 8;
   localparam int TIMEOUT = 16;
   localparam logic [1:0] ACK = 2'd0, NAK = 2'd1, STL = 2'd2, DAT = 2'd3;
   localparam logic [1:0] T_SETUP = 2'd0, T_IN = 2'd1, T_OUT = 2'd2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tok_valid = 0, dat_valid = 0, host_ack = 0, fw_arm = 0, fw_stall = 0;
   logic [1:0] tok_kind = '0;
   logic [LEN_W-1:0] dat_len = '0, rx_space = 7'd16, tx_fill = '0;
   logic rsp_valid, rx_wr, tx_en, in_done;
   logic [1:0] rsp_kind;
   logic [LEN_W-1:0] rsp_len;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [9:0] q_rsp[$];
   string      q_tag[$];
   string      q_done[$];

   always #2 clk = ~clk;

   usb_ctrl_ep_responder #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .TIMEOUT(TIMEOUT)) u_usb_ctrl_ep_responder (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
      .dat_valid(dat_valid), .dat_len(dat_len), .host_ack(host_ack),
      .fw_arm(fw_arm), .fw_stall(fw_stall), .rx_space(rx_space), .tx_fill(tx_fill),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_len(rsp_len),
      .rx_wr(rx_wr), .tx_en(tx_en), .in_done(in_done));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_rsp(input logic [1:0] k, input int len, input bit wr, input string tag);
      q_rsp.push_back({k, LEN_W'(len), wr});
      q_tag.push_back(tag);
   endtask

   // monitor: pop and compare at negedge
   always @(negedge clk) if (rst_n && !finished) begin
      if (rsp_valid) begin
         if (q_rsp.size() == 0) check(1'b0, "R10 unexpected response", {rsp_kind, rsp_len, rx_wr}, 0);
         else begin
            logic [9:0] e;
            string t;
            e = q_rsp.pop_front();
            t = q_tag.pop_front();
            check({rsp_kind, rsp_len, rx_wr} == e, t, {rsp_kind, rsp_len, rx_wr}, e);
         end
      end else if (rx_wr) check(1'b0, "R3 write without response", 1, 0);
      if (in_done) begin
         if (q_done.size() == 0) check(1'b0, "R9 unexpected in_done", 1, 0);
         else begin
            string t;
            t = q_done.pop_front();
            check(1'b1, t, 1, 1);
         end
      end
   end

   task automatic tok(input logic [1:0] k);
      @(negedge clk); tok_valid = 1; tok_kind = k;
      @(negedge clk); tok_valid = 0;
   endtask
   task automatic dat(input int n);
      @(negedge clk); dat_valid = 1; dat_len = LEN_W'(n);
      @(negedge clk); dat_valid = 0;
   endtask
   task automatic hack();
      @(negedge clk); host_ack = 1;
      @(negedge clk); host_ack = 0;
   endtask
   task automatic arm();
      @(negedge clk); fw_arm = 1;
      @(negedge clk); fw_arm = 0;
   endtask
   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic drained(input string tag);
      settle(2);
      check(q_rsp.size() == 0, tag, q_rsp.size(), 0);
      check(q_done.size() == 0, tag, q_done.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(rsp_valid == 0 && tx_en == 0 && in_done == 0, "R10 reset outputs",
            {rsp_valid, tx_en, in_done}, 0);
      rst_n = 1;
      settle(2);

      // R5: NAK, then an OUT handled straight away
      expect_rsp(NAK, 0, 0, "R5 IN while disabled");
      tok(T_IN);
      expect_rsp(ACK, 4, 1, "R3 OUT fits");
      tok(T_OUT); dat(4);
      drained("R5 no handshake wait after NAK");

      // R3 boundary: exactly full, then one over
      expect_rsp(ACK, 16, 1, "R3 OUT equals space");
      tok(T_OUT); dat(16);
      expect_rsp(NAK, 0, 0, "R3 OUT exceeds space");
      tok(T_OUT); dat(17);
      drained("R3 queue");

      // R1 / R2
      expect_rsp(ACK, 8, 1, "R1 setup 8 bytes");
      tok(T_SETUP); dat(8);
      tok(T_SETUP); dat(5);
      expect_rsp(NAK, 0, 0, "R2 idle after ignored setup");
      tok(T_IN);
      drained("R2 no reply to short setup");

      // R6 / R7: two-packet drain
      tx_fill = 7'd12;
      arm();
      check(tx_en == 1, "R7 armed", tx_en, 1);
      expect_rsp(DAT, 8, 0, "R6 first packet capped");
      tok(T_IN);
      settle(2);
      check(q_done.size() == 0 && tx_en == 1, "R6 no done before ACK", q_done.size(), 0);
      q_done.push_back("R6 done after ACK");
      hack();
      settle(1);
      check(tx_en == 1, "R7 stays set with bytes left", tx_en, 1);
      tx_fill = 7'd4;
      expect_rsp(DAT, 4, 0, "R6 tail packet");
      tok(T_IN);
      q_done.push_back("R7 done on last");
      hack();
      settle(1);
      check(tx_en == 0, "R7 clears after drain", tx_en, 0);
      drained("R7 queue");

      // R8 zero-length
      tx_fill = 7'd0;
      arm();
      expect_rsp(DAT, 0, 0, "R8 zero length packet");
      tok(T_IN);
      q_done.push_back("R8 zlp done");
      hack();
      settle(1);
      check(tx_en == 0, "R8 clears after ZLP", tx_en, 0);

      // R9 timeout and retry
      tx_fill = 7'd6;
      arm();
      expect_rsp(DAT, 6, 0, "R9 first try");
      tok(T_IN);
      settle(TIMEOUT + 4);
      check(tx_en == 1, "R9 flag kept after timeout", tx_en, 1);
      check(q_done.size() == 0, "R9 no done on timeout", 0, 0);
      expect_rsp(DAT, 6, 0, "R9 retry same length");
      tok(T_IN);
      q_done.push_back("R9 retry done");
      hack();
      settle(1);
      check(tx_en == 0, "R9 clears after retry", tx_en, 0);

      // R4 stall priority, R1 clears
      @(negedge clk); fw_stall = 1;
      @(negedge clk); fw_stall = 0;
      tx_fill = 7'd3;
      arm();
      expect_rsp(STL, 0, 0, "R4 IN stalled");
      tok(T_IN);
      settle(1);
      check(tx_en == 1, "R4 flag untouched", tx_en, 1);
      expect_rsp(STL, 0, 0, "R4 OUT stalled");
      tok(T_OUT); dat(2);
      expect_rsp(ACK, 8, 1, "R1 setup during stall");
      tok(T_SETUP); dat(8);
      expect_rsp(DAT, 3, 0, "R1 stall cleared");
      tok(T_IN);
      q_done.push_back("R4 done after unstall");
      hack();
      drained("R4 final queue");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL R10 watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule